// File: doc/BRIEF.md
# Self-Timed Dataflow Arithmetic Element

This block is one arithmetic cell of a coarse-grained dataflow array. It takes operand packets on three data channels (a, b, c) and a one-bit event channel, and it returns result packets on one data channel and one-bit flags on an event channel. Every channel uses valid/ready handshaking. A packet moves on a rising clock edge where both valid and ready are high.

The cell never runs on a clock schedule. It computes as soon as every operand that its opcode needs is held in its input registers and the output side can take the result. A finished result waits in an output buffer register until the consumer takes it. A small configuration port selects the opcode. The same port can also preload any of the three data operand registers with a constant, which then serves every firing without being used up. The operations are two-input fixed-point arithmetic and logic, plus three-input work: multiply-add, a two-value sort that gives the smaller value, and a terminal counter. The cell raises event packets for signed overflow and for counter terminal count.

Top module: `dfe_alu_cell`

## Requirements
- R1: The cell fires only when every operand register its opcode needs is full. Needed operands by opcode: a and b for codes 0-6 and 8; a, b and c for code 7; a only for code 9; a, b and the event input for code 10.
- R2: While y_valid is high and y_ready is low, y_data holds its value. No new result replaces it until the consumer takes it.
- R3: An operand channel's ready is high only when that operand is needed by the current opcode, its register is empty and not a constant, and cfg_we is low. A streamed operand is used up by a firing. After reset the opcode is 0, so a_ready and b_ready are high and c_ready and ev_in_ready are low.
- R4: A configuration write with cfg_addr 0 sets the opcode to cfg_wdata[3:0], empties all operand registers, clears all constants and zeroes the counter. Writes with cfg_addr 1, 2 or 3 preload a, b or c with cfg_wdata as a constant that is never used up.
- R5: Two-input operations: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, 5 gives a shifted left by b[4:0], 6 gives the low 32 bits of a*b.
- R6: Code 7 gives the low 32 bits of a*b+c. Its overflow flag is signed overflow of adding c to the low product word.
- R7: Code 8 gives the smaller of a and b, compared as signed values.
- R8: Code 9 outputs a count that starts at 0 and rises by one per firing. When the count equals a, the event flag is 1 and the next count is 0.
- R9: Code 10 gives b when the event operand is 1 and a when it is 0.
- R10: Codes 0, 1, 7 and 9 emit exactly one event packet per firing, in the same cycle as the result. The flag is signed overflow for 0, 1 and 7, and terminal count for 9. Other codes emit no event packet. An event packet holds its value until it is taken.
- R11: While cfg_we is high the cell does not fire, and all operand ready outputs are low.
- R12: Codes 11 to 15 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 = opcode, 1/2/3 = constant for a/b/c |
| cfg_wdata | input | 32 | Configuration write data |
| a_valid | input | 1 | Operand a packet valid |
| a_ready | output | 1 | Operand a register can accept |
| a_data | input | 32 | Operand a packet |
| b_valid | input | 1 | Operand b packet valid |
| b_ready | output | 1 | Operand b register can accept |
| b_data | input | 32 | Operand b packet |
| c_valid | input | 1 | Operand c packet valid |
| c_ready | output | 1 | Operand c register can accept |
| c_data | input | 32 | Operand c packet |
| ev_in_valid | input | 1 | Event operand valid |
| ev_in_ready | output | 1 | Event operand register can accept |
| ev_in_data | input | 1 | Event operand value |
| y_valid | output | 1 | Result packet valid |
| y_ready | input | 1 | Consumer takes result |
| y_data | output | 32 | Result packet |
| ev_out_valid | output | 1 | Event packet valid |
| ev_out_ready | input | 1 | Consumer takes event |
| ev_out_data | output | 1 | Event flag |

## Verification
The bench builds the cell with its default 32-bit data width. At that width the signed-overflow boundaries at 0x7FFFFFFF and 0x80000000 can be reached directly, and so can the wrap of the five-bit shift amount (a shift by 33 acts as a shift by 1). A counter limit of 2 is enough to drive the terminal event and the restart within a few firings. Back-pressure tests hold y_ready low while fresh operands queue. This reaches the case where the buffered result must stay put, and the case where a take and a new firing fall in the same cycle.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef logic [3:0] opc_t;

  localparam opc_t OPC_ADD = 4'd0;
  localparam opc_t OPC_SUB = 4'd1;
  localparam opc_t OPC_AND = 4'd2;
  localparam opc_t OPC_OR  = 4'd3;
  localparam opc_t OPC_XOR = 4'd4;
  localparam opc_t OPC_SHL = 4'd5;
  localparam opc_t OPC_MUL = 4'd6;
  localparam opc_t OPC_MAC = 4'd7;
  localparam opc_t OPC_MIN = 4'd8;
  localparam opc_t OPC_CNT = 4'd9;
  localparam opc_t OPC_SEL = 4'd10;

  localparam int NUM_OPND = 3;

  // bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = event operand
  typedef logic [NUM_OPND:0] need_t;

  function automatic need_t op_needs(opc_t op);
    case (op)
      OPC_MAC: op_needs = 4'b0111;
      OPC_CNT: op_needs = 4'b0001;
      OPC_SEL: op_needs = 4'b1011;
      default: op_needs = 4'b0011;
    endcase
  endfunction

  function automatic logic op_emits(opc_t op);
    op_emits = (op == OPC_ADD) || (op == OPC_SUB) ||
               (op == OPC_MAC) || (op == OPC_CNT);
  endfunction

  function automatic logic op_legal(opc_t op);
    op_legal = (op <= OPC_SEL);
  endfunction
endpackage

// File: rtl/dfe_opnd_reg.sv
module dfe_opnd_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         pre,
  input  logic [W-1:0] pre_data,
  input  logic         need,
  input  logic         blk,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q, full_d;
  logic         const_q, const_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en;

  assign in_ready = need && !full_q && !const_q && !blk;

  always_comb begin
    full_d  = full_q;
    const_d = const_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (clr) begin
      full_d  = 1'b0;
      const_d = 1'b0;
    end else if (pre) begin
      full_d  = 1'b1;
      const_d = 1'b1;
      data_d  = pre_data;
      data_en = 1'b1;
    end else if (in_valid && in_ready) begin
      full_d  = 1'b1;
      data_d  = in_data;
      data_en = 1'b1;
    end else if (take && !const_q) begin
      full_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      const_q <= 1'b0;
      data_q  <= '0;
    end else begin
      full_q  <= full_d;
      const_q <= const_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/dfe_exec.sv
module dfe_exec
  import dfe_pkg::*;
#(
  parameter int DW = 32
) (
  input  opc_t          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic          e,
  input  logic [DW-1:0] cnt,
  output logic [DW-1:0] y,
  output logic          flag
);
  localparam int SHW = $clog2(DW);
  localparam int MSB = DW - 1;

  logic [DW-1:0] sum, dif, prod, mac;
  logic          ovf_add, ovf_sub, ovf_mac;

  assign sum  = a + b;
  assign dif  = a - b;
  assign prod = a * b;
  assign mac  = prod + c;

  assign ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
  assign ovf_mac = (prod[MSB] == c[MSB]) && (mac[MSB] != prod[MSB]);

  always_comb begin
    y    = '0;
    flag = 1'b0;
    case (op)
      OPC_ADD: begin y = sum; flag = ovf_add; end
      OPC_SUB: begin y = dif; flag = ovf_sub; end
      OPC_AND: y = a & b;
      OPC_OR:  y = a | b;
      OPC_XOR: y = a ^ b;
      OPC_SHL: y = a << b[SHW-1:0];
      OPC_MUL: y = prod;
      OPC_MAC: begin y = mac; flag = ovf_mac; end
      OPC_MIN: y = ($signed(a) < $signed(b)) ? a : b;
      OPC_CNT: begin y = cnt; flag = (cnt == a); end
      OPC_SEL: y = e ? b : a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dfe_out_buf.sv
module dfe_out_buf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         can_push,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  logic         full_q, full_d;
  logic [W-1:0] data_q;

  assign can_push = !full_q || ready;

  always_comb begin
    full_d = full_q;
    if (push)       full_d = 1'b1;
    else if (ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (push) data_q <= din;
    end
  end

  assign valid = full_q;
  assign dout  = data_q;
endmodule

// File: rtl/dfe_alu_cell.sv
module dfe_alu_cell
  import dfe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [DW-1:0] b_data,
  input  logic          c_valid,
  output logic          c_ready,
  input  logic [DW-1:0] c_data,
  input  logic          ev_in_valid,
  output logic          ev_in_ready,
  input  logic          ev_in_data,
  output logic          y_valid,
  input  logic          y_ready,
  output logic [DW-1:0] y_data,
  output logic          ev_out_valid,
  input  logic          ev_out_ready,
  output logic          ev_out_data
);
  opc_t          op_q, op_d;
  logic          op_wr;
  need_t         need;
  logic [NUM_OPND:0] full_vec;

  logic [NUM_OPND-1:0]         in_v, in_r, pre_v;
  logic [NUM_OPND-1:0][DW-1:0] in_d, opnd;

  logic          e_opnd;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] res;
  logic          res_flag;
  logic          emits, have_all, y_can, e_can, fire;

  // configuration decode
  assign op_wr = cfg_we && (cfg_addr == 2'd0);
  assign need  = op_needs(op_q);
  assign emits = op_emits(op_q);

  always_comb begin
    op_d = op_q;
    if (op_wr) op_d = cfg_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OPC_ADD;
    else        op_q <= op_d;
  end

  assign in_v = {c_valid, b_valid, a_valid};
  assign in_d = {c_data, b_data, a_data};
  assign a_ready = in_r[0];
  assign b_ready = in_r[1];
  assign c_ready = in_r[2];

  // data operand registers
  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    assign pre_v[i] = cfg_we && (cfg_addr == 2'(i + 1));
    dfe_opnd_reg #(.W(DW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (op_wr),
      .pre      (pre_v[i]),
      .pre_data (cfg_wdata),
      .need     (need[i]),
      .blk      (cfg_we),
      .in_valid (in_v[i]),
      .in_ready (in_r[i]),
      .in_data  (in_d[i]),
      .take     (fire && need[i]),
      .full     (full_vec[i]),
      .data     (opnd[i])
    );
  end

  // event operand register
  dfe_opnd_reg #(.W(1)) u_ev_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op_wr),
    .pre      (1'b0),
    .pre_data (1'b0),
    .need     (need[NUM_OPND]),
    .blk      (cfg_we),
    .in_valid (ev_in_valid),
    .in_ready (ev_in_ready),
    .in_data  (ev_in_data),
    .take     (fire && need[NUM_OPND]),
    .full     (full_vec[NUM_OPND]),
    .data     (e_opnd)
  );

  // firing rule
  assign have_all = &(~need | full_vec);
  assign fire = !cfg_we && op_legal(op_q) && have_all && y_can &&
                (!emits || e_can);

  dfe_exec #(.DW(DW)) u_exec (
    .op   (op_q),
    .a    (opnd[0]),
    .b    (opnd[1]),
    .c    (opnd[2]),
    .e    (e_opnd),
    .cnt  (cnt_q),
    .y    (res),
    .flag (res_flag)
  );

  // terminal counter state
  always_comb begin
    cnt_d = cnt_q;
    if (op_wr)
      cnt_d = '0;
    else if (fire && (op_q == OPC_CNT))
      cnt_d = res_flag ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  dfe_out_buf #(.W(DW)) u_ybuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fire),
    .din      (res),
    .can_push (y_can),
    .valid    (y_valid),
    .ready    (y_ready),
    .dout     (y_data)
  );

  dfe_out_buf #(.W(1)) u_ebuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fire && emits),
    .din      (res_flag),
    .can_push (e_can),
    .valid    (ev_out_valid),
    .ready    (ev_out_ready),
    .dout     (ev_out_data)
  );
endmodule

// File: rtl/dfe_alu_cell_chk.sv
module dfe_alu_cell_chk
  import dfe_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          a_ready,
  input logic          b_ready,
  input logic          c_ready,
  input logic          ev_in_ready,
  input logic          y_valid,
  input logic          y_ready,
  input logic [DW-1:0] y_data,
  input logic          ev_out_valid,
  input logic          ev_out_ready,
  input logic          ev_out_data,
  input opc_t          op_q
);
  // R2
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));

  // R10
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_valid && !ev_out_ready) |=> (ev_out_valid && $stable(ev_out_data)));

  // R10
  ev_with_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_out_valid) |-> y_valid);

  // R11
  cfg_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !(a_ready || b_ready || c_ready || ev_in_ready));

  // R11
  cfg_nofire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !y_valid) |=> !y_valid);

  // R3
  c_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_ready |-> (op_q == OPC_MAC));

  // R12
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_legal(op_q) && !y_valid) |=> !y_valid);
endmodule

bind dfe_alu_cell dfe_alu_cell_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .a_ready      (a_ready),
  .b_ready      (b_ready),
  .c_ready      (c_ready),
  .ev_in_ready  (ev_in_ready),
  .y_valid      (y_valid),
  .y_ready      (y_ready),
  .y_data       (y_data),
  .ev_out_valid (ev_out_valid),
  .ev_out_ready (ev_out_ready),
  .ev_out_data  (ev_out_data),
  .op_q         (op_q)
);

// File: tb/dfe_alu_cell_bench.sv
module dfe_alu_cell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WD_CYCLES = 20000;

  typedef struct packed {
    logic [3:0]    op;
    logic [31:0]   a;
    logic [31:0]   b;
    logic [31:0]   c;
    logic          e;
    logic [31:0]   y;
    logic          has_ev;
    logic          ev;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'd5,          32'd7,          32'd0,          1'b0, 32'd12,         1'b1, 1'b0},
    '{4'd0,  32'h7FFF_FFFF,  32'd1,          32'd0,          1'b0, 32'h8000_0000,  1'b1, 1'b1},
    '{4'd0,  32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd0,          1'b0, 32'hFFFF_FFFE,  1'b1, 1'b0},
    '{4'd1,  32'd3,          32'd5,          32'd0,          1'b0, 32'hFFFF_FFFE,  1'b1, 1'b0},
    '{4'd1,  32'h8000_0000,  32'd1,          32'd0,          1'b0, 32'h7FFF_FFFF,  1'b1, 1'b1},
    '{4'd2,  32'hF0F0,       32'hFF00,       32'd0,          1'b0, 32'hF000,       1'b0, 1'b0},
    '{4'd3,  32'hF0F0,       32'hFF00,       32'd0,          1'b0, 32'hFFF0,       1'b0, 1'b0},
    '{4'd4,  32'hF0F0,       32'hFF00,       32'd0,          1'b0, 32'h0FF0,       1'b0, 1'b0},
    '{4'd5,  32'd1,          32'd4,          32'd0,          1'b0, 32'd16,         1'b0, 1'b0},
    '{4'd5,  32'd3,          32'd33,         32'd0,          1'b0, 32'd6,          1'b0, 1'b0},
    '{4'd6,  32'd6,          32'd7,          32'd0,          1'b0, 32'd42,         1'b0, 1'b0},
    '{4'd7,  32'd3,          32'd4,          32'd5,          1'b0, 32'd17,         1'b1, 1'b0},
    '{4'd7,  32'h4000_0000,  32'd1,          32'h4000_0000,  1'b0, 32'h8000_0000,  1'b1, 1'b1},
    '{4'd8,  32'hFFFF_FFFD,  32'd2,          32'd0,          1'b0, 32'hFFFF_FFFD,  1'b0, 1'b0},
    '{4'd8,  32'd9,          32'd4,          32'd0,          1'b0, 32'd4,          1'b0, 1'b0},
    '{4'd10, 32'd10,         32'd20,         32'd0,          1'b1, 32'd20,         1'b0, 1'b0},
    '{4'd10, 32'd10,         32'd20,         32'd0,          1'b0, 32'd10,         1'b0, 1'b0}
  };

  logic          clk, rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic          a_valid, a_ready, b_valid, b_ready, c_valid, c_ready;
  logic [DW-1:0] a_data, b_data, c_data;
  logic          ev_in_valid, ev_in_ready, ev_in_data;
  logic          y_valid, y_ready;
  logic [DW-1:0] y_data;
  logic          ev_out_valid, ev_out_ready, ev_out_data;

  int checks = 0;
  int errors = 0;

  dfe_alu_cell #(.DW(DW)) u_dfe_alu_cell (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .ev_in_valid(ev_in_valid), .ev_in_ready(ev_in_ready), .ev_in_data(ev_in_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
    .ev_out_valid(ev_out_valid), .ev_out_ready(ev_out_ready), .ev_out_data(ev_out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] addr, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_a(input logic [DW-1:0] d);
    @(negedge clk); a_valid = 1'b1; a_data = d;
    while (!a_ready) @(negedge clk);
    @(negedge clk); a_valid = 1'b0;
  endtask

  task automatic send_b(input logic [DW-1:0] d);
    @(negedge clk); b_valid = 1'b1; b_data = d;
    while (!b_ready) @(negedge clk);
    @(negedge clk); b_valid = 1'b0;
  endtask

  task automatic send_c(input logic [DW-1:0] d);
    @(negedge clk); c_valid = 1'b1; c_data = d;
    while (!c_ready) @(negedge clk);
    @(negedge clk); c_valid = 1'b0;
  endtask

  task automatic send_e(input logic d);
    @(negedge clk); ev_in_valid = 1'b1; ev_in_data = d;
    while (!ev_in_ready) @(negedge clk);
    @(negedge clk); ev_in_valid = 1'b0;
  endtask

  task automatic take(output logic [DW-1:0] y, output logic has_ev, output logic ev);
    @(negedge clk); y_ready = 1'b1; ev_out_ready = 1'b1;
    while (!y_valid) @(negedge clk);
    y = y_data; has_ev = ev_out_valid; ev = ev_out_data;
    @(negedge clk); y_ready = 1'b0; ev_out_ready = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd7:    req_of = "R6";
      4'd8:    req_of = "R7";
      4'd10:   req_of = "R9";
      default: req_of = "R5";
    endcase
  endfunction

  logic [DW-1:0] got;
  logic          got_has, got_ev;

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    a_valid = 0; b_valid = 0; c_valid = 0; ev_in_valid = 0;
    a_data = '0; b_data = '0; c_data = '0; ev_in_data = 0;
    y_ready = 0; ev_out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state: opcode 0 needs a and b
    check(!y_valid && !ev_out_valid, "R3 reset outputs", {y_valid, ev_out_valid}, 0);
    check(a_ready && b_ready && !c_ready && !ev_in_ready, "R3 reset readies",
          {a_ready, b_ready, c_ready, ev_in_ready}, 4'b1100);

    // vector table: R5 R6 R7 R9 and R10 presence/flag
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, {28'd0, VECS[i].op});
      send_a(VECS[i].a);
      if (VECS[i].op != 4'd9) send_b(VECS[i].b);
      if (VECS[i].op == 4'd7) send_c(VECS[i].c);
      if (VECS[i].op == 4'd10) send_e(VECS[i].e);
      take(got, got_has, got_ev);
      check(got == VECS[i].y, req_of(VECS[i].op), got, VECS[i].y);
      check(got_has == VECS[i].has_ev, "R10 event presence", got_has, VECS[i].has_ev);
      if (VECS[i].has_ev)
        check(got_ev == VECS[i].ev, "R10 event flag", got_ev, VECS[i].ev);
    end

    // R11: readies drop while configuring
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd0;
    @(negedge clk);
    check(!a_ready && !b_ready, "R11 readies low", {a_ready, b_ready}, 0);
    @(negedge clk); cfg_we = 1'b0;

    // R4: constant b is never consumed
    cfg_write(2'd0, 32'd0);
    cfg_write(2'd2, 32'd100);
    @(negedge clk);
    check(!b_ready, "R4 const b ready", b_ready, 0);
    send_a(32'd1);
    take(got, got_has, got_ev);
    check(got == 32'd101, "R4 const first", got, 101);
    send_a(32'd2);
    take(got, got_has, got_ev);
    check(got == 32'd102, "R4 const reused", got, 102);
    cfg_write(2'd0, 32'd0);
    @(negedge clk);
    check(b_ready, "R4 opcode write clears const", b_ready, 1);

    // R2: back-pressure keeps result
    send_a(32'd1); send_b(32'd2);
    send_a(32'd10); send_b(32'd20);
    repeat (4) @(negedge clk);
    check(y_valid && y_data == 32'd3, "R2 held result", y_data, 3);
    take(got, got_has, got_ev);
    check(got == 32'd3, "R2 first out", got, 3);
    take(got, got_has, got_ev);
    check(got == 32'd30, "R2 second out", got, 30);

    // R1: MAC waits for c
    cfg_write(2'd0, 32'd7);
    send_a(32'd2); send_b(32'd3);
    repeat (5) @(negedge clk);
    check(!y_valid, "R1 no fire without c", y_valid, 0);
    send_c(32'd4);
    take(got, got_has, got_ev);
    check(got == 32'd10, "R1 fires with c", got, 10);

    // R8: counter limit 2 -> 0,1,2(term),0
    cfg_write(2'd0, 32'd9);
    @(negedge clk);
    check(!b_ready && !c_ready, "R3 counter unneeded readies", {b_ready, c_ready}, 0);
    for (int k = 0; k < 4; k++) begin
      send_a(32'd2);
      take(got, got_has, got_ev);
      check(got == 32'(k % 3), "R8 count", got, 32'(k % 3));
      check(got_has && (got_ev == (k == 2)), "R8 terminal event",
            {got_has, got_ev}, {1'b1, (k == 2)});
    end

    // R12: reserved code never fires
    cfg_write(2'd0, 32'd12);
    send_a(32'd1); send_b(32'd1);
    repeat (5) @(negedge clk);
    check(!y_valid, "R12 reserved no fire", y_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule